// File: doc/BRIEF.md
# Converter Power Sequencer

This block controls power to a sampling converter's core and to its on-chip voltage reference. The serial front end decodes each control byte and passes three fields to the block. One field chooses between the internal and an external reference. One field keeps the reference powered. One field keeps the core running. The front end also signals when a start bit arrives and when a conversion finishes.

A control byte that asks for power-down does not act at once. The request is held as pending and is applied only when the conversion started by that byte completes. The next start bit powers the core again. It also powers the reference again, but only if the last accepted control byte chose the internal reference.

After either supply is switched on, a counter runs for a fixed number of system-clock cycles before the matching ready flag rises. This gives the analog circuitry time to settle. The serial path is not gated by this block, so the last result can still be read while the converter is powered down.

Top module: `pd_power_ctrl`

## Requirements
- R1: While `rst` is high, and in the cycle after it is released, all five outputs are low and the stored reference choice is "external".
- R2: A `start_pulse` sets `core_en` in the next cycle. In that same cycle `ref_en` is also set, but only if the last legal control byte had `cfg_int_ref`=1.
- R3: A legal `ctl_load` with `cfg_int_ref`=1, `cfg_ref_hold`=1 and `cfg_core_run`=1 sets `ref_en` in the next cycle if it is low.
- R4: Any other legal `ctl_load` leaves both enables unchanged until the next `conv_done`. On that `conv_done`, `core_en` becomes `cfg_core_run` and `ref_en` becomes `cfg_int_ref & cfg_ref_hold & cfg_core_run`. When `cfg_int_ref`=0, `cfg_ref_hold` has no effect.
- R5: The field combination `cfg_int_ref`=1, `cfg_ref_hold`=1, `cfg_core_run`=0 is reserved. Loading it sets `mode_err` in the next cycle. It creates no pending request and does not change the stored reference choice. The next legal `ctl_load` clears `mode_err`.
- R6: `core_ready` rises exactly `CORE_WAKE_CYC` cycles after `core_en` rises. It falls in the same cycle that `core_en` falls, and it is never high while `core_en` is low.
- R7: `ref_ready` rises exactly `REF_WAKE_CYC` cycles after `ref_en` rises. It falls together with `ref_en`, and it is never high while `ref_en` is low.
- R8: When `start_pulse` and `conv_done` arrive in the same cycle, the start takes priority. The pending power-down request is discarded, and both enables are left as the start rule sets them.
- R9: A `conv_done` with no pending request changes no output.
- R10: `core_en` and `ref_en` fall only in the cycle after a `conv_done` that did not coincide with a `start_pulse`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous reset, active high |
| start_pulse | input | 1 | One-cycle pulse: start bit received |
| ctl_load | input | 1 | One-cycle pulse: control fields valid |
| cfg_int_ref | input | 1 | 1 = internal reference selected |
| cfg_ref_hold | input | 1 | 1 = keep internal reference powered |
| cfg_core_run | input | 1 | 1 = keep core powered after conversion |
| conv_done | input | 1 | One-cycle pulse: conversion finished |
| core_en | output | 1 | Core power enable |
| ref_en | output | 1 | Internal reference power enable |
| core_ready | output | 1 | Core wake-up delay elapsed |
| ref_ready | output | 1 | Reference settling delay elapsed |
| mode_err | output | 1 | Reserved field combination was loaded |

## Verification
A start bit and the end of a conversion can arrive in the same clock cycle. In that case the block must choose between powering up and applying the power-down that is still pending. The bench provokes this case by loading a byte that requests power-down and then pulsing `start_pulse` and `conv_done` together. It then expects both enables and both ready flags to stay high. A later `conv_done` on its own must also leave everything unchanged, which shows that the discarded request did not come back.

// File: rtl/pd_pkg.sv
package pd_pkg;
  typedef struct packed {
    logic int_ref;
    logic ref_hold;
    logic core_run;
  } pd_cfg_t;

  typedef struct packed {
    logic legal;
    logic tgt_core;
    logic tgt_ref;
  } pd_target_t;
endpackage

// File: rtl/pd_mode_decode.sv
module pd_mode_decode
  import pd_pkg::*;
(
  input  pd_cfg_t    cfg,
  output pd_target_t tgt
);
  always_comb begin
    tgt.legal    = !(cfg.int_ref && cfg.ref_hold && !cfg.core_run);
    tgt.tgt_core = cfg.core_run;
    tgt.tgt_ref  = cfg.int_ref && cfg.ref_hold && cfg.core_run;
  end
endmodule

// File: rtl/pd_wake_timer.sv
module pd_wake_timer #(
  parameter int unsigned DELAY = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic en_nx,
  output logic ready
);
  localparam int unsigned W = (DELAY < 2) ? 1 : $clog2(DELAY + 1);
  localparam logic [W-1:0] LIMIT = W'(DELAY);

  logic [W-1:0] cnt;

  // counts edges since the enable went high; ready holds once the limit is met
  always_ff @(posedge clk) begin
    if (rst || !en_nx) begin
      cnt   <= '0;
      ready <= 1'b0;
    end else begin
      if (cnt != LIMIT) cnt <= cnt + 1'b1;
      ready <= ready | (cnt == LIMIT);
    end
  end
endmodule

// File: rtl/pd_power_ctrl.sv
module pd_power_ctrl
  import pd_pkg::*;
#(
  parameter int unsigned CORE_WAKE_CYC = 2500,
  parameter int unsigned REF_WAKE_CYC  = 1500000
) (
  input  logic clk,
  input  logic rst,
  input  logic start_pulse,
  input  logic ctl_load,
  input  logic cfg_int_ref,
  input  logic cfg_ref_hold,
  input  logic cfg_core_run,
  input  logic conv_done,
  output logic core_en,
  output logic ref_en,
  output logic core_ready,
  output logic ref_ready,
  output logic mode_err
);
  pd_cfg_t    cfg;
  pd_target_t tgt;

  logic pend_vld, pend_core, pend_ref;
  logic sel_int;
  logic core_nx, ref_nx;

  assign cfg = '{int_ref: cfg_int_ref, ref_hold: cfg_ref_hold, core_run: cfg_core_run};

  pd_mode_decode dec_i (.cfg(cfg), .tgt(tgt));

  // next power state: deferred shutdown, immediate reference enable, start wake
  always_comb begin
    core_nx = core_en;
    ref_nx  = ref_en;
    if (conv_done && !start_pulse && pend_vld) begin
      core_nx = pend_core;
      ref_nx  = pend_ref;
    end
    if (ctl_load && tgt.legal && tgt.tgt_ref) ref_nx = 1'b1;
    if (start_pulse) begin
      core_nx = 1'b1;
      if (sel_int) ref_nx = 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      core_en   <= 1'b0;
      ref_en    <= 1'b0;
      pend_vld  <= 1'b0;
      pend_core <= 1'b0;
      pend_ref  <= 1'b0;
      sel_int   <= 1'b0;
      mode_err  <= 1'b0;
    end else begin
      core_en <= core_nx;
      ref_en  <= ref_nx;
      if (start_pulse || conv_done) pend_vld <= 1'b0;
      if (ctl_load) begin
        mode_err <= !tgt.legal;
        if (tgt.legal) begin
          pend_vld  <= 1'b1;
          pend_core <= tgt.tgt_core;
          pend_ref  <= tgt.tgt_ref;
          sel_int   <= cfg.int_ref;
        end
      end
    end
  end

  pd_wake_timer #(.DELAY(CORE_WAKE_CYC)) core_tmr_i (
    .clk(clk), .rst(rst), .en_nx(core_nx), .ready(core_ready)
  );

  pd_wake_timer #(.DELAY(REF_WAKE_CYC)) ref_tmr_i (
    .clk(clk), .rst(rst), .en_nx(ref_nx), .ready(ref_ready)
  );
endmodule

// File: rtl/pd_power_ctrl_chk.sv
module pd_power_ctrl_chk #(
  parameter int unsigned CORE_WAKE_CYC = 2500,
  parameter int unsigned REF_WAKE_CYC  = 1500000
) (
  input logic clk,
  input logic rst,
  input logic start_pulse,
  input logic ctl_load,
  input logic cfg_int_ref,
  input logic cfg_ref_hold,
  input logic cfg_core_run,
  input logic conv_done,
  input logic core_en,
  input logic ref_en,
  input logic core_ready,
  input logic ref_ready,
  input logic mode_err
);
  int unsigned core_on_cnt, ref_on_cnt;

  always_ff @(posedge clk) begin
    if (rst || !core_en) core_on_cnt <= 0;
    else if (core_on_cnt <= CORE_WAKE_CYC) core_on_cnt <= core_on_cnt + 1;
    if (rst || !ref_en) ref_on_cnt <= 0;
    else if (ref_on_cnt <= REF_WAKE_CYC) ref_on_cnt <= ref_on_cnt + 1;
  end

  // R6
  core_ready_gated_chk: assert property (@(posedge clk) disable iff (rst)
    core_ready |-> core_en);
  // R6
  core_ready_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(core_ready) |-> (core_on_cnt == CORE_WAKE_CYC));
  // R7
  ref_ready_gated_chk: assert property (@(posedge clk) disable iff (rst)
    ref_ready |-> ref_en);
  // R7
  ref_ready_delay_chk: assert property (@(posedge clk) disable iff (rst)
    $rose(ref_ready) |-> (ref_on_cnt == REF_WAKE_CYC));
  // R2
  start_wakes_core_chk: assert property (@(posedge clk) disable iff (rst)
    start_pulse |=> core_en);
  // R5
  reserved_flag_chk: assert property (@(posedge clk) disable iff (rst)
    (ctl_load && cfg_int_ref && cfg_ref_hold && !cfg_core_run) |=> mode_err);
  // R8
  start_beats_done_chk: assert property (@(posedge clk) disable iff (rst)
    (start_pulse && conv_done && core_en) |=> (core_en && $stable(ref_en) || ref_en));
  // R10
  core_off_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(core_en) |-> ($past(conv_done) && !$past(start_pulse)));
  // R10
  ref_off_at_done_chk: assert property (@(posedge clk) disable iff (rst)
    $fell(ref_en) |-> ($past(conv_done) && !$past(start_pulse)));
endmodule

bind pd_power_ctrl pd_power_ctrl_chk #(
  .CORE_WAKE_CYC(CORE_WAKE_CYC),
  .REF_WAKE_CYC (REF_WAKE_CYC)
) chk_i (
  .clk(clk), .rst(rst), .start_pulse(start_pulse), .ctl_load(ctl_load),
  .cfg_int_ref(cfg_int_ref), .cfg_ref_hold(cfg_ref_hold),
  .cfg_core_run(cfg_core_run), .conv_done(conv_done),
  .core_en(core_en), .ref_en(ref_en), .core_ready(core_ready),
  .ref_ready(ref_ready), .mode_err(mode_err)
);

// File: tb/pd_power_ctrl_tb_top.sv
module pd_power_ctrl_tb_top;
  localparam int CW = 8;
  localparam int RW = 30;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic start_pulse = 1'b0, ctl_load = 1'b0, conv_done = 1'b0;
  logic cfg_int_ref = 1'b0, cfg_ref_hold = 1'b0, cfg_core_run = 1'b0;
  logic core_en, ref_en, core_ready, ref_ready, mode_err;

  int cyc = 0;
  int n_chk = 0;
  int n_bad = 0;
  bit finished = 1'b0;

  typedef struct {
    int         when;
    logic [4:0] exp;
    string      tag;
  } item_t;
  item_t sb_q[$];

  always #4 clk = ~clk;
  always @(posedge clk) cyc <= cyc + 1;

  pd_power_ctrl #(.CORE_WAKE_CYC(CW), .REF_WAKE_CYC(RW)) dut_i (
    .clk(clk), .rst(rst), .start_pulse(start_pulse), .ctl_load(ctl_load),
    .cfg_int_ref(cfg_int_ref), .cfg_ref_hold(cfg_ref_hold),
    .cfg_core_run(cfg_core_run), .conv_done(conv_done),
    .core_en(core_en), .ref_en(ref_en), .core_ready(core_ready),
    .ref_ready(ref_ready), .mode_err(mode_err)
  );

  // expected order: {core_en, ref_en, core_ready, ref_ready, mode_err}
  task automatic chk(input int dly, input logic [4:0] e, input string tag);
    item_t it;
    it.when = cyc + dly;
    it.exp  = e;
    it.tag  = tag;
    sb_q.push_back(it);
  endtask

  task automatic drive(input logic s, input logic l, input logic i,
                       input logic r, input logic c, input logic d);
    start_pulse = s; ctl_load = l; cfg_int_ref = i;
    cfg_ref_hold = r; cfg_core_run = c; conv_done = d;
    @(negedge clk);
    start_pulse = 0; ctl_load = 0; conv_done = 0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  // monitor: pops expectations due in this cycle and compares
  always @(negedge clk) begin
    while (sb_q.size() > 0 && sb_q[0].when <= cyc) begin
      item_t it;
      logic [4:0] act;
      it  = sb_q.pop_front();
      act = {core_en, ref_en, core_ready, ref_ready, mode_err};
      n_chk++;
      if (it.when != cyc || act !== it.exp) begin
        n_bad++;
        $display("FAIL %s cycle %0d: actual %b expected %b", it.tag, cyc, act, it.exp);
      end
    end
  end

  initial begin
    idle(4);
    chk(1, 5'b00000, "R1 reset");
    idle(1);
    rst = 0;
    chk(1, 5'b00000, "R1 after release");
    idle(2);
    // first start: core only, reference choice external after reset
    chk(1, 5'b10000, "R2 core wakes");
    chk(CW, 5'b10000, "R6 core not ready yet");
    chk(CW + 1, 5'b10100, "R6 core ready");
    drive(1, 0, 0, 0, 0, 0);
    idle(CW + 2);
    // full active mode turns reference on at load
    chk(1, 5'b11100, "R3 ref on at load");
    chk(RW, 5'b11100, "R7 ref not ready yet");
    chk(RW + 1, 5'b11110, "R7 ref ready");
    drive(0, 1, 1, 1, 1, 0);
    idle(RW + 2);
    chk(1, 5'b11110, "R4 full active survives done");
    drive(0, 0, 0, 0, 0, 1);
    idle(2);
    // reference shutdown after conversion
    chk(1, 5'b11110, "R2 start with all on");
    drive(1, 0, 0, 0, 0, 0);
    chk(1, 5'b11110, "R4 ref shutdown deferred");
    drive(0, 1, 1, 0, 1, 0);
    chk(1, 5'b10100, "R4 ref off at done");
    drive(0, 0, 0, 0, 0, 1);
    idle(2);
    // start wakes reference because internal was chosen
    chk(1, 5'b11100, "R2 ref wakes on start");
    chk(RW + 1, 5'b11110, "R7 ref ready again");
    drive(1, 0, 0, 0, 0, 0);
    idle(RW + 2);
    // external reference, core kept
    chk(1, 5'b11110, "R4 external deferred");
    drive(0, 1, 0, 1, 1, 0);
    chk(1, 5'b10100, "R4 external ref off at done");
    drive(0, 0, 0, 0, 0, 1);
    chk(1, 5'b10100, "R2 no ref wake with external");
    drive(1, 0, 0, 0, 0, 0);
    chk(1, 5'b10100, "R4 core-down deferred");
    drive(0, 1, 0, 0, 0, 0);
    chk(1, 5'b00000, "R4 full power down at done");
    drive(0, 0, 0, 0, 0, 1);
    chk(3, 5'b00000, "R9 stays down");
    idle(4);
    chk(1, 5'b10000, "R2 core wakes, ref stays off");
    chk(CW + 1, 5'b10100, "R6 core ready after wake");
    drive(1, 0, 0, 0, 0, 0);
    idle(CW + 2);
    // reserved combination
    chk(1, 5'b10101, "R5 reserved flagged");
    drive(0, 1, 1, 1, 0, 0);
    chk(1, 5'b10101, "R5 R9 reserved creates no pending");
    drive(0, 0, 0, 0, 0, 1);
    chk(1, 5'b10100, "R5 legal load clears error");
    drive(0, 1, 1, 0, 0, 0);
    chk(1, 5'b00000, "R4 internal full power down");
    drive(0, 0, 0, 0, 0, 1);
    idle(2);
    chk(1, 5'b11000, "R2 both wake on start");
    chk(CW + 1, 5'b11100, "R6 core ready first");
    chk(RW + 1, 5'b11110, "R7 ref ready later");
    drive(1, 0, 0, 0, 0, 0);
    idle(RW + 2);
    // start and done together
    chk(1, 5'b11110, "R4 pending power down");
    drive(0, 1, 0, 0, 0, 0);
    chk(1, 5'b11110, "R8 start beats done");
    drive(1, 0, 0, 0, 0, 1);
    chk(1, 5'b11110, "R8 R9 pending discarded");
    drive(0, 0, 0, 0, 0, 1);
    idle(3);
    if (!finished) begin
      finished = 1'b1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      finished = 1'b1;
      n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule